// File: doc/BRIEF.md
# Programmable Product-Term Logic Block

This block models one programmable logic block of a complex programmable logic device. A flat configuration word decides everything it does. A shared array of product terms is built from 36 block inputs. An allocator hands each of the 16 macrocells a window of those terms, and any subset of the window can be selected. Each cell ORs its selected terms into a sum. The sum can be passed straight through, captured in an edge-triggered flip-flop, or held in a transparent latch. After that an optional inversion is applied before the value reaches the pin driver and the feedback path.

Each cell picks its register clock from four global clocks or from a product term. A single bit per block sets which clock edge or latch phase is active. A cell marked as buried stops driving its pin, but its value still reaches feedback. A buried cell can also act as an input register or input latch for the pin of its paired neighbour. The pin input path is kept apart from feedback, so every pin can always be read back as an input.

Top module: `lb_logic_block`

## Requirements
- R1: Term t is the AND of block inputs selected in its true mask (cfg bits t*72+j) and complemented inputs selected in its complement mask (cfg bits t*72+36+j); a term with both masks empty is 0.
- R2: Cell i control sits at cfg offset 5760+24*i with mode in bits [1:0], invert in [2], clock select in [5:3], buried in [6], input-register in [7] and term-enable mask in [23:8]. Mask bit k enables term (5*i+k) mod 80, and the cell sum is the OR of all enabled terms.
- R3: A single product term may feed several neighbouring cells at once through their overlapping windows.
- R4: A cell with an all-zero term mask has a sum of 0 before the inversion stage.
- R5: The invert bit complements the cell value on both pin_o and fb_o.
- R6: Mode 1 captures the cell data on the active edge of the selected clock and holds it otherwise; mode 0 (and 3) is combinational.
- R7: Mode 2 is a latch that is transparent while the selected clock is at its active level and holds while it is inactive.
- R8: Clock select 0 to 3 picks gclk_i[sel]; select 4 to 7 picks the product term at position 0 of the cell's own window.
- R9: The last cfg bit (6144) inverts the selected clock for every cell in the block, so flip-flops capture on the falling edge.
- R10: A buried cell drives oe_o low, and its value still appears on fb_o.
- R11: A buried cell with the input-register bit set takes its data from pin_i of its neighbour (index i XOR 1) instead of its sum, in any mode.
- R12: pin_in_o always equals pin_i, whatever the cell configuration.
- R13: rst asynchronously clears every flip-flop and latch to 0, so registered cells show the invert bit at their outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high reset of cell storage |
| gclk_i | input | 4 | Global clocks |
| cfg_i | input | 6145 | Configuration word |
| blk_in_i | input | 36 | Block inputs to the product-term array |
| pin_i | input | 16 | Values read from the cell pins |
| pin_o | output | 16 | Pin drive values |
| oe_o | output | 16 | Pin output enables |
| fb_o | output | 16 | Feedback values toward the interconnect |
| pin_in_o | output | 16 | Pin input values toward the interconnect |

## Verification
The hardest case to reach is a product-term clock. The cell clock then comes from block inputs rather than from a clock pin, and a bad edge there would corrupt the captured data. The stimulus keeps the data term steady and toggles only the input behind window position 0. That term is left out of the cell's own sum, so every edge seen at the output can be traced to that one input. Input registers on buried cells are driven the same way: the neighbour pin changes, and the cell's own sum is held at a value that differs from it.

// File: rtl/lb_cfg_pkg.sv
package lb_cfg_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_DFF   = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_SPARE = 2'd3
  } mc_mode_e;

  localparam int NUM_GCLK = 4;
  localparam int CTL_W    = 8;

  // packed order, msb first: inreg, buried, csel, invert, mode
  typedef struct packed {
    logic       inreg;
    logic       buried;
    logic [2:0] csel;
    logic       invert;
    mc_mode_e   mode;
  } mc_ctl_t;

endpackage

// File: rtl/lb_pterm_array.sv
module lb_pterm_array #(
  parameter int NUM_IN = 36,
  parameter int NUM_PT = 80,
  localparam int TERM_W = NUM_PT * 2 * NUM_IN
) (
  input  logic              chk_clk,
  input  logic              rst,
  input  logic [TERM_W-1:0] term_cfg_i,
  input  logic [NUM_IN-1:0] blk_in_i,
  output logic [NUM_PT-1:0] term_o
);

  for (genvar t = 0; t < NUM_PT; t++) begin : g_term
    logic [NUM_IN-1:0] true_sel;
    logic [NUM_IN-1:0] comp_sel;
    logic              any_sel;
    logic              true_ok;
    logic              comp_ok;

    assign true_sel = term_cfg_i[t*2*NUM_IN +: NUM_IN];
    assign comp_sel = term_cfg_i[t*2*NUM_IN + NUM_IN +: NUM_IN];
    assign any_sel  = |(true_sel | comp_sel);
    assign true_ok  = &(~true_sel | blk_in_i);
    assign comp_ok  = &(~comp_sel | ~blk_in_i);
    assign term_o[t] = any_sel & true_ok & comp_ok;

    assert_empty_term_R1: assert property (@(posedge chk_clk) disable iff (rst)
      ((true_sel | comp_sel) == '0) |-> !term_o[t]);
  end

endmodule

// File: rtl/lb_allocator.sv
module lb_allocator #(
  parameter int NUM_PT = 80,
  parameter int NUM_MC = 16,
  parameter int WIN    = 16,
  localparam int STEP  = NUM_PT / NUM_MC
) (
  input  logic [NUM_PT-1:0]     term_i,
  input  logic [NUM_MC*WIN-1:0] mask_i,
  output logic [NUM_MC-1:0]     sum_o,
  output logic [NUM_MC-1:0]     ptclk_o
);

  for (genvar i = 0; i < NUM_MC; i++) begin : g_cell
    logic [WIN-1:0] picked;
    for (genvar k = 0; k < WIN; k++) begin : g_pos
      localparam int IDX = (i * STEP + k) % NUM_PT;
      assign picked[k] = term_i[IDX] & mask_i[i*WIN + k];
    end
    localparam int FIRST = (i * STEP) % NUM_PT;
    assign sum_o[i]   = |picked;
    assign ptclk_o[i] = term_i[FIRST];
  end

endmodule

// File: rtl/lb_macrocell.sv
module lb_macrocell
  import lb_cfg_pkg::*;
(
  input  logic                chk_clk,
  input  logic                rst,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                blk_pol_i,
  input  logic                ptclk_i,
  input  logic                sum_i,
  input  logic                pin_nb_i,
  input  mc_ctl_t             ctl_i,
  output logic                out_o,
  output logic                oe_o
);

  logic sel_clk;
  logic eff_clk;
  logic data;
  logic ff_q;
  logic lat_q;
  logic core;

  assign sel_clk = ctl_i.csel[2] ? ptclk_i : gclk_i[ctl_i.csel[1:0]];
  assign eff_clk = sel_clk ^ blk_pol_i;
  assign data    = (ctl_i.buried & ctl_i.inreg) ? pin_nb_i : sum_i;

  always_ff @(posedge eff_clk or posedge rst) begin
    if (rst) ff_q <= 1'b0;
    else     ff_q <= data;
  end

  always_latch begin
    if (rst)          lat_q <= 1'b0;
    else if (eff_clk) lat_q <= data;
  end

  always_comb begin
    case (ctl_i.mode)
      MODE_DFF:   core = ff_q;
      MODE_LATCH: core = lat_q;
      default:    core = data;
    endcase
  end

  assign out_o = core ^ ctl_i.invert;
  assign oe_o  = ~ctl_i.buried;

  assert_latch_follows_R7: assert property (@(posedge chk_clk) disable iff (rst)
    (ctl_i.mode == MODE_LATCH && eff_clk) |-> ((out_o ^ ctl_i.invert) == data));

  assert_inreg_source_R11: assert property (@(posedge chk_clk) disable iff (rst)
    (ctl_i.buried && ctl_i.inreg && ctl_i.mode == MODE_COMB) |-> (out_o == (pin_nb_i ^ ctl_i.invert)));

endmodule

// File: rtl/lb_logic_block.sv
module lb_logic_block
  import lb_cfg_pkg::*;
#(
  parameter int NUM_IN = 36,
  parameter int NUM_MC = 16,
  parameter int NUM_PT = 80,
  parameter int WIN    = 16,
  localparam int TERM_W = NUM_PT * 2 * NUM_IN,
  localparam int MC_W   = CTL_W + WIN,
  localparam int CFG_W  = TERM_W + NUM_MC * MC_W + 1
) (
  input  logic                rst,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic [NUM_IN-1:0]   blk_in_i,
  input  logic [NUM_MC-1:0]   pin_i,
  output logic [NUM_MC-1:0]   pin_o,
  output logic [NUM_MC-1:0]   oe_o,
  output logic [NUM_MC-1:0]   fb_o,
  output logic [NUM_MC-1:0]   pin_in_o
);

  logic [NUM_PT-1:0]     terms;
  logic [NUM_MC*WIN-1:0] masks;
  logic [NUM_MC-1:0]     sums;
  logic [NUM_MC-1:0]     ptclks;
  logic [NUM_MC-1:0]     cell_out;
  logic                  blk_pol;

  assign blk_pol  = cfg_i[CFG_W-1];
  assign pin_in_o = pin_i;

  lb_pterm_array #(.NUM_IN(NUM_IN), .NUM_PT(NUM_PT)) u_terms (
    .chk_clk    (gclk_i[0]),
    .rst        (rst),
    .term_cfg_i (cfg_i[TERM_W-1:0]),
    .blk_in_i   (blk_in_i),
    .term_o     (terms)
  );

  lb_allocator #(.NUM_PT(NUM_PT), .NUM_MC(NUM_MC), .WIN(WIN)) u_alloc (
    .term_i  (terms),
    .mask_i  (masks),
    .sum_o   (sums),
    .ptclk_o (ptclks)
  );

  for (genvar i = 0; i < NUM_MC; i++) begin : g_mc
    localparam int BASE = TERM_W + i * MC_W;
    localparam int NB   = ((i ^ 1) < NUM_MC) ? (i ^ 1) : i;
    mc_ctl_t ctl;

    assign ctl = mc_ctl_t'(cfg_i[BASE +: CTL_W]);
    assign masks[i*WIN +: WIN] = cfg_i[BASE + CTL_W +: WIN];

    lb_macrocell u_cell (
      .chk_clk   (gclk_i[0]),
      .rst       (rst),
      .gclk_i    (gclk_i),
      .blk_pol_i (blk_pol),
      .ptclk_i   (ptclks[i]),
      .sum_i     (sums[i]),
      .pin_nb_i  (pin_i[NB]),
      .ctl_i     (ctl),
      .out_o     (cell_out[i]),
      .oe_o      (oe_o[i])
    );

    assign pin_o[i] = cell_out[i];
    assign fb_o[i]  = cell_out[i];

    assert_empty_sum_R4: assert property (@(posedge gclk_i[0]) disable iff (rst)
      (ctl.mode == MODE_COMB && !(ctl.buried && ctl.inreg) && masks[i*WIN +: WIN] == '0)
        |-> (fb_o[i] == ctl.invert));
  end

endmodule

// File: tb/lb_logic_block_test.sv
module lb_logic_block_test;

  localparam int CLK_PERIOD = 10;
  localparam int NI     = 36;
  localparam int NMC    = 16;
  localparam int NPT    = 80;
  localparam int TERM_W = NPT * 2 * NI;
  localparam int MCW    = 24;
  localparam int CFG_W  = TERM_W + NMC * MCW + 1;
  localparam logic [1:0] M_COMB = 2'd0, M_DFF = 2'd1, M_LAT = 2'd2;

  logic             rst;
  logic             gclk0;
  logic [3:1]       gman;
  logic [CFG_W-1:0] cfg;
  logic [NI-1:0]    blk_in;
  logic [NMC-1:0]   pin_in;
  logic [NMC-1:0]   pin_o, oe_o, fb_o, pin_in_o;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  lb_logic_block uut (
    .rst      (rst),
    .gclk_i   ({gman, gclk0}),
    .cfg_i    (cfg),
    .blk_in_i (blk_in),
    .pin_i    (pin_in),
    .pin_o    (pin_o),
    .oe_o     (oe_o),
    .fb_o     (fb_o),
    .pin_in_o (pin_in_o)
  );

  initial gclk0 = 1'b0;
  always #(CLK_PERIOD/2) gclk0 = ~gclk0;

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req, input string what);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic set_term(input int t, input int idx, input bit comp);
    cfg[t*2*NI + (comp ? NI : 0) + idx] = 1'b1;
  endtask

  task automatic set_cell(input int i, input logic [15:0] mask, input logic [1:0] mode,
                          input bit inv, input logic [2:0] csel, input bit buried, input bit inreg);
    int b;
    b = TERM_W + i * MCW;
    cfg[b +: 2] = mode;
    cfg[b + 2] = inv;
    cfg[b + 3 +: 3] = csel;
    cfg[b + 6] = buried;
    cfg[b + 7] = inreg;
    cfg[b + 8 +: 16] = mask;
  endtask

  task automatic fresh();
    rst = 1'b1; cfg = '0; blk_in = '0; pin_in = '0; gman = '0;
    #7 rst = 1'b0;
    #3;
  endtask

  task automatic pulse(input int k);
    #2 gman[k] = 1'b1;
    #3 gman[k] = 1'b0;
    #2;
  endtask

  task automatic t_reset_state();
    rst = 1'b1; cfg = '0; blk_in = '1; pin_in = '0; gman = '0;
    #3;
    check(fb_o, 16'h0000, "R13", "feedback in reset");
    check(pin_o, 16'h0000, "R13", "pins in reset");
    check(oe_o, 16'hFFFF, "R10", "all enables with nothing buried");
    rst = 1'b0; #2;
  endtask

  task automatic t_term_logic();
    fresh();
    set_term(0, 2, 0); set_term(0, 7, 1);
    set_cell(0, 16'h0001, M_COMB, 0, 0, 0, 0);
    set_cell(1, 16'h0001, M_COMB, 0, 0, 0, 0);
    blk_in[2] = 1; blk_in[7] = 0; #1;
    check(fb_o[0], 1, "R1", "in2 & ~in7 true");
    blk_in[7] = 1; #1;
    check(fb_o[0], 0, "R1", "complemented input high");
    blk_in = '1; #1;
    check(fb_o[1], 0, "R1", "empty term stays 0");
    blk_in = '0; #1;
    check(fb_o[0], 0, "R1", "true input low");
  endtask

  task automatic t_sharing();
    fresh();
    set_term(12, 4, 0);
    set_cell(0, 16'h1000, M_COMB, 0, 0, 0, 0);
    set_cell(1, 16'h0080, M_COMB, 0, 0, 0, 0);
    set_cell(2, 16'h0004, M_COMB, 0, 0, 0, 0);
    set_term(15, 0, 0); set_term(20, 1, 0);
    set_cell(3, 16'h0021, M_COMB, 0, 0, 0, 0);
    set_term(0, 9, 0);
    set_cell(15, 16'h0020, M_COMB, 0, 0, 0, 0);
    blk_in[4] = 1; #1;
    check(fb_o[2:0], 3'b111, "R3", "shared term reaches three cells");
    blk_in[4] = 0; #1;
    check(fb_o[2:0], 3'b000, "R3", "shared term low");
    blk_in[0] = 1; #1;
    check(fb_o[3], 1, "R2", "OR first term");
    blk_in[0] = 0; blk_in[1] = 1; #1;
    check(fb_o[3], 1, "R2", "OR second term");
    blk_in[1] = 0; #1;
    check(fb_o[3], 0, "R2", "OR none");
    blk_in[9] = 1; #1;
    check(fb_o[15], 1, "R2", "window wraps to term 0");
    check(fb_o[0], 0, "R2", "cell 0 ignores unselected term 0");
  endtask

  task automatic t_polarity();
    fresh();
    set_cell(4, 16'h0000, M_COMB, 0, 0, 0, 0);
    set_cell(5, 16'h0000, M_COMB, 1, 0, 0, 0);
    set_term(30, 3, 0);
    set_cell(6, 16'h0001, M_COMB, 1, 0, 0, 0);
    blk_in = '1; #1;
    check(fb_o[4], 0, "R4", "zero terms give 0");
    check(fb_o[5], 1, "R4", "zero terms inverted give 1");
    check(fb_o[6], 0, "R5", "inverted high sum");
    check(pin_o[6], 0, "R5", "pin shows inverted value");
    blk_in[3] = 0; #1;
    check(fb_o[6], 1, "R5", "inverted low sum");
  endtask

  task automatic t_dff();
    fresh();
    set_term(30, 5, 0);
    set_cell(6, 16'h0001, M_DFF, 0, 3'd1, 0, 0);
    blk_in[5] = 1; #1;
    check(fb_o[6], 0, "R6", "no edge yet");
    pulse(1);
    check(fb_o[6], 1, "R6", "captured on gclk1");
    blk_in[5] = 0; #1;
    check(fb_o[6], 1, "R6", "holds between edges");
    pulse(2);
    check(fb_o[6], 1, "R8", "other clock ignored");
    pulse(1);
    check(fb_o[6], 0, "R6", "captured 0");
  endtask

  task automatic t_latch();
    fresh();
    set_term(35, 6, 0);
    set_cell(7, 16'h0001, M_LAT, 0, 3'd2, 0, 0);
    gman[2] = 1; blk_in[6] = 1; #1;
    check(fb_o[7], 1, "R7", "transparent high");
    blk_in[6] = 0; #1;
    check(fb_o[7], 0, "R7", "transparent low");
    blk_in[6] = 1; #1;
    gman[2] = 0; #1;
    blk_in[6] = 0; #1;
    check(fb_o[7], 1, "R7", "holds when gate closed");
  endtask

  task automatic t_ptclk();
    fresh();
    set_term(40, 10, 0); set_term(41, 11, 0);
    set_cell(8, 16'h0002, M_DFF, 0, 3'd4, 0, 0);
    blk_in[11] = 1; #1;
    check(fb_o[8], 0, "R8", "before term clock edge");
    blk_in[10] = 1; #1;
    check(fb_o[8], 1, "R8", "term clock rising edge");
    blk_in[11] = 0; #1;
    blk_in[10] = 0; #1;
    check(fb_o[8], 1, "R8", "falling term clock no capture");
    blk_in[10] = 1; #1;
    check(fb_o[8], 0, "R8", "second term clock edge");
  endtask

  task automatic t_blkpol();
    fresh();
    set_term(30, 5, 0);
    set_cell(6, 16'h0001, M_DFF, 0, 3'd1, 0, 0);
    cfg[CFG_W-1] = 1'b1; #1;
    blk_in[5] = 1; #1;
    gman[1] = 1; #1;
    check(fb_o[6], 0, "R9", "rising edge ignored");
    gman[1] = 0; #1;
    check(fb_o[6], 1, "R9", "falling edge captures");
  endtask

  task automatic t_buried();
    fresh();
    set_term(45, 12, 0);
    set_cell(9, 16'h0001, M_COMB, 0, 0, 1, 0);
    blk_in[12] = 1; #1;
    check(oe_o[9], 0, "R10", "buried cell enable");
    check(oe_o[8], 1, "R10", "unburied neighbour enable");
    check(fb_o[9], 1, "R10", "buried feedback");
    pin_in = 16'hA5C3; #1;
    check(pin_in_o, 16'hA5C3, "R12", "pin path pattern 1");
    check(fb_o[9], 1, "R12", "feedback independent of own pin");
    pin_in = 16'h5A3C; #1;
    check(pin_in_o, 16'h5A3C, "R12", "pin path pattern 2");
  endtask

  task automatic t_inreg();
    fresh();
    set_term(50, 13, 0);
    set_cell(10, 16'h0001, M_DFF, 0, 3'd3, 1, 1);
    set_cell(11, 16'h0000, M_LAT, 0, 3'd2, 1, 1);
    blk_in[13] = 1; pin_in[11] = 0; #1;
    pulse(3);
    check(fb_o[10], 0, "R11", "input register ignores sum");
    pin_in[11] = 1; #1;
    pulse(3);
    check(fb_o[10], 1, "R11", "input register takes neighbour pin");
    gman[2] = 1; pin_in[10] = 1; #1;
    check(fb_o[11], 1, "R11", "input latch transparent");
    pin_in[10] = 0; #1;
    check(fb_o[11], 0, "R11", "input latch follows");
    pin_in[10] = 1; #1;
    gman[2] = 0; #1;
    pin_in[10] = 0; #1;
    check(fb_o[11], 1, "R11", "input latch holds");
  endtask

  task automatic t_async_reset();
    fresh();
    set_term(60, 14, 0);
    set_cell(12, 16'h0001, M_DFF, 1, 3'd1, 0, 0);
    blk_in[14] = 1; #1;
    pulse(1);
    check(fb_o[12], 0, "R13", "stored 1 inverted");
    rst = 1; #1;
    check(fb_o[12], 1, "R13", "async clear shows invert bit");
    rst = 0; #1;
    check(fb_o[12], 1, "R13", "stays cleared without edge");
  endtask

  initial begin
    rst = 1'b1; cfg = '0; blk_in = '0; pin_in = '0; gman = '0;
    t_reset_state();
    t_term_logic();
    t_sharing();
    t_polarity();
    t_dff();
    t_latch();
    t_ptclk();
    t_blkpol();
    t_buried();
    t_inreg();
    t_async_reset();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge gclk0);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule